// File: doc/BRIEF.md
# Inter-Core Interrupt Signalling Unit

This unit lets the cores of a small cluster (up to four by default) interrupt one another. All cores share a single command port. Each command carries four things: a valid strobe, a two-bit opcode, an argument naming a core, and the identity of the core that issued it. Pending requests are kept as a matrix of sender/receiver bits. Each receiver has one level interrupt line. That line is the OR of every sender bit aimed at it. When several senders target the same receiver at once, their requests merge onto that one line.

A receiver finds out who interrupted it by issuing a source query. It then acknowledges each sender on its own, with one command per sender. A sender can poll whether its earlier request to a given core is still waiting. The answer comes back in a registered readback word on the cycle after the command. A core cannot interrupt itself through this unit, and a request to a pair that is already pending is not counted a second time.

Top module: `icsu_top`

## Requirements
- R1: After reset every pending bit is clear, `irqOut` is all zero and `rdData` is zero.
- R2: A valid command with opcode 0 (raise) and `cmdArg` different from `cmdSrc` sets pending bit [cmdSrc][cmdArg]. `irqOut[cmdArg]` is high from the clock edge that accepts the command.
- R3: A raise (opcode 0) whose `cmdArg` equals `cmdSrc` changes no pending bit and no output.
- R4: A valid command with opcode 1 (status) loads `rdData` at its accepting edge. Bit 0 takes pending bit [cmdSrc][cmdArg] and all other bits are 0.
- R5: A valid command with opcode 2 (source query) loads `rdData` at its accepting edge. Bit s takes pending bit [s][cmdSrc], one bit per sender core.
- R6: Requests from several senders to one receiver assert the single line `irqOut[receiver]`, and a source query then shows several bits set.
- R7: A valid command with opcode 3 (acknowledge) clears pending bit [cmdArg][cmdSrc] only. Every other pending bit is unchanged.
- R8: `irqOut[r]` stays high while any sender bit toward core r is still pending.
- R9: Raising an already pending pair keeps a single pending bit, so one acknowledge clears it.
- R10: `rdData` changes only on status and source-query commands. It holds its value across raise, acknowledge and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe, one command per cycle |
| cmdOp | input | 2 | Opcode: 0 raise, 1 status, 2 source query, 3 acknowledge |
| cmdArg | input | IDX_W | Target core (raise, status) or sender core (acknowledge) |
| cmdSrc | input | IDX_W | Identity of the issuing core |
| rdData | output | NUM_CORES | Registered readback word |
| irqOut | output | NUM_CORES | Level interrupt, one per receiving core |

## Verification
A wrong pending bit shows up on `irqOut` right after the edge that wrote it. It also shows up in the next status or source-query readback of that pair. An acknowledge that clears too much is caught by the following source query, or by a line dropping while another sender is still pending. A self-raise that leaks state is caught at once on the issuer's own interrupt line. The bench compares both outputs against its own pair matrix after every command, so any divergence is reported on the cycle after the command that caused it.

// File: rtl/icsu_pkg.sv
package icsu_pkg;

  typedef enum logic [1:0] {
    OP_RAISE  = 2'd0,
    OP_STATUS = 2'd1,
    OP_WHO    = 2'd2,
    OP_ACK    = 2'd3
  } icsuOp_e;

  typedef struct packed {
    logic raise;
    logic ack;
    logic status;
    logic who;
  } icsuStrobe_t;

endpackage

// File: rtl/icsu_ctrl.sv
module icsu_ctrl
  import icsu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [IDX_W-1:0] cmdArg,
  input  logic [IDX_W-1:0] cmdSrc,
  output icsuStrobe_t      stb
);

  logic argOk;
  logic srcOk;

  assign argOk = (int'(cmdArg) < NUM_CORES);
  assign srcOk = (int'(cmdSrc) < NUM_CORES);

  always_comb begin
    stb = '0;
    if (cmdValid && srcOk) begin
      unique case (icsuOp_e'(cmdOp))
        OP_RAISE:  stb.raise  = argOk && (cmdArg != cmdSrc);
        OP_STATUS: stb.status = 1'b1;
        OP_WHO:    stb.who    = 1'b1;
        OP_ACK:    stb.ack    = argOk;
        default:   stb        = '0;
      endcase
    end
  end

endmodule

// File: rtl/icsu_datapath.sv
module icsu_datapath
  import icsu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PAIRS = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  icsuStrobe_t          stb,
  input  logic [IDX_W-1:0]     cmdArg,
  input  logic [IDX_W-1:0]     cmdSrc,
  output logic [PAIRS-1:0]     pendFlat,
  output logic [NUM_CORES-1:0] rdData,
  output logic [NUM_CORES-1:0] irqOut
);

  logic [NUM_CORES-1:0] srcVec;
  logic                 statusBit;

  for (genvar s = 0; s < NUM_CORES; s++) begin : g_sender
    for (genvar r = 0; r < NUM_CORES; r++) begin : g_receiver
      if (s == r) begin : g_diag
        assign pendFlat[s*NUM_CORES+r] = 1'b0;
      end else begin : g_pair
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            pendFlat[s*NUM_CORES+r] <= 1'b0;
          end else if (stb.raise && cmdSrc == IDX_W'(s) && cmdArg == IDX_W'(r)) begin
            pendFlat[s*NUM_CORES+r] <= 1'b1;
          end else if (stb.ack && cmdArg == IDX_W'(s) && cmdSrc == IDX_W'(r)) begin
            pendFlat[s*NUM_CORES+r] <= 1'b0;
          end
        end
      end
    end
  end

  always_comb begin
    irqOut = '0;
    for (int r = 0; r < NUM_CORES; r++) begin
      for (int s = 0; s < NUM_CORES; s++) begin
        irqOut[r] = irqOut[r] | pendFlat[s*NUM_CORES+r];
      end
    end
  end

  always_comb begin
    srcVec    = '0;
    statusBit = 1'b0;
    for (int s = 0; s < NUM_CORES; s++) begin
      for (int r = 0; r < NUM_CORES; r++) begin
        if (cmdSrc == IDX_W'(r)) srcVec[s] = pendFlat[s*NUM_CORES+r];
        if (cmdSrc == IDX_W'(s) && cmdArg == IDX_W'(r)) statusBit = pendFlat[s*NUM_CORES+r];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (stb.status) begin
      rdData <= {{(NUM_CORES-1){1'b0}}, statusBit};
    end else if (stb.who) begin
      rdData <= srcVec;
    end
  end

endmodule

// File: rtl/icsu_top.sv
module icsu_top
  import icsu_pkg::*;
#(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PAIRS = NUM_CORES * NUM_CORES
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cmdValid,
  input  logic [1:0]           cmdOp,
  input  logic [IDX_W-1:0]     cmdArg,
  input  logic [IDX_W-1:0]     cmdSrc,
  output logic [NUM_CORES-1:0] rdData,
  output logic [NUM_CORES-1:0] irqOut
);

  icsuStrobe_t      stb;
  logic [PAIRS-1:0] pendFlat;

  icsu_ctrl #(.NUM_CORES(NUM_CORES)) ctrl_i (
    .cmdValid (cmdValid),
    .cmdOp    (cmdOp),
    .cmdArg   (cmdArg),
    .cmdSrc   (cmdSrc),
    .stb      (stb)
  );

  icsu_datapath #(.NUM_CORES(NUM_CORES)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .cmdArg   (cmdArg),
    .cmdSrc   (cmdSrc),
    .pendFlat (pendFlat),
    .rdData   (rdData),
    .irqOut   (irqOut)
  );

endmodule

// File: rtl/icsu_checker.sv
module icsu_checker #(
  parameter int NUM_CORES = 4,
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int PAIRS = NUM_CORES * NUM_CORES
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cmdValid,
  input logic [1:0]           cmdOp,
  input logic [IDX_W-1:0]     cmdArg,
  input logic [IDX_W-1:0]     cmdSrc,
  input logic [PAIRS-1:0]     pendFlat,
  input logic [NUM_CORES-1:0] rdData,
  input logic [NUM_CORES-1:0] irqOut
);

  logic [PAIRS-1:0] ackMask;
  logic             pairBit;

  always_comb begin
    ackMask = '0;
    pairBit = 1'b0;
    for (int s = 0; s < NUM_CORES; s++) begin
      for (int r = 0; r < NUM_CORES; r++) begin
        if (cmdArg == IDX_W'(s) && cmdSrc == IDX_W'(r)) ackMask[s*NUM_CORES+r] = 1'b1;
        if (cmdSrc == IDX_W'(s) && cmdArg == IDX_W'(r)) pairBit = pendFlat[s*NUM_CORES+r];
      end
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (irqOut == '0 && rdData == '0));

  a_r3_self_raise_inert: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && cmdArg == cmdSrc) |=> $stable(pendFlat));

  a_r2_raise_asserts: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd0 && cmdArg != cmdSrc) |=> irqOut[$past(cmdArg)]);

  a_r4_status_word: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd1) |=> (rdData == {{(NUM_CORES-1){1'b0}}, $past(pairBit)}));

  a_r7_ack_only_one: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd3) |=>
      (((pendFlat ^ $past(pendFlat)) & ~$past(ackMask)) == '0) &&
      ((pendFlat & $past(ackMask)) == '0));

  a_r10_readback_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && (cmdOp == 2'd1 || cmdOp == 2'd2)) |=> $stable(rdData));

  for (genvar r = 0; r < NUM_CORES; r++) begin : g_line
    a_r8_line_holds: assert property (@(posedge clk) disable iff (!rstN)
      (irqOut[r] && !(cmdValid && cmdOp == 2'd3 && cmdSrc == IDX_W'(r))) |=> irqOut[r]);
  end

endmodule

bind icsu_top icsu_checker #(.NUM_CORES(NUM_CORES)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .cmdValid (cmdValid),
  .cmdOp    (cmdOp),
  .cmdArg   (cmdArg),
  .cmdSrc   (cmdSrc),
  .pendFlat (pendFlat),
  .rdData   (rdData),
  .irqOut   (irqOut)
);

// File: tb/icsu_top_tb_top.sv
`timescale 1ns/1ps
module icsu_top_tb_top;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'd0;
  logic [1:0] cmdArg = 2'd0;
  logic [1:0] cmdSrc = 2'd0;
  logic [N-1:0] rdData;
  logic [N-1:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit model [N][N];
  logic [N-1:0] expRd = '0;

  always #2 clk = ~clk;

  icsu_top #(.NUM_CORES(N)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .cmdSrc(cmdSrc), .rdData(rdData), .irqOut(irqOut)
  );

  function automatic logic [N-1:0] modelIrq();
    logic [N-1:0] v = '0;
    for (int r = 0; r < N; r++)
      for (int s = 0; s < N; s++) v[r] |= model[s][r];
    return v;
  endfunction

  function automatic logic [N-1:0] modelWho(int rcv);
    logic [N-1:0] v = '0;
    for (int s = 0; s < N; s++) v[s] = model[s][rcv];
    return v;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic issue(int op, int arg, int src, string req);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'(op); cmdArg = 2'(arg); cmdSrc = 2'(src);
    case (op)
      1: expRd = {3'b000, model[src][arg]};
      2: expRd = modelWho(src);
      default: ;
    endcase
    if (op == 0 && arg != src) model[src][arg] = 1'b1;
    if (op == 3) model[arg][src] = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    check({req, " irq"}, irqOut, modelIrq());
    check({req, " rd"}, rdData, expRd);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 irq", irqOut, '0);
    check("R1 rd", rdData, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", irqOut, '0);

    issue(0, 2, 2, "R3 self raise");
    issue(1, 2, 2, "R3 self status");
    issue(0, 1, 0, "R2 raise 0->1");
    issue(1, 1, 0, "R4 status pending");
    issue(1, 2, 0, "R4 status idle");
    issue(0, 1, 2, "R6 raise 2->1");
    issue(0, 1, 3, "R6 raise 3->1");
    issue(2, 0, 1, "R6 who multi");
    issue(0, 1, 0, "R9 repeat raise");
    issue(3, 0, 1, "R7 ack 0");
    issue(1, 1, 0, "R9 status after one ack");
    issue(2, 0, 1, "R8 who after ack");
    issue(3, 2, 1, "R8 ack 2");
    issue(0, 3, 1, "R10 raise hold");
    issue(3, 3, 1, "R8 ack last");
    issue(2, 0, 3, "R5 who at 3");
    issue(3, 1, 3, "R7 ack own line");
    issue(2, 0, 1, "R5 who empty");

    for (int i = 0; i < 400; i++) begin
      int op  = int'($urandom_range(3, 0));
      int arg = int'($urandom_range(N-1, 0));
      int src = int'($urandom_range(N-1, 0));
      issue(op, arg, src, "R2 R4 R5 R7 R10 random");
      if ($urandom_range(3, 0) == 0) begin
        @(negedge clk);
        check("R10 idle hold", rdData, expRd);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule